// File: doc/BRIEF.md
# Secure Debug Access Gate

This block stands between an external debug port and a processor core and decides whether the port may take control of the core. It holds a one-bit port shield that comes out of reset closed. It qualifies each debug-entry request from the core against the enable bit of the privilege level the core runs at, and it checks a password supplied over the port against a secret fixed at build time. Debug access, and the raise of the effective privilege to machine level that comes with it, needs all three: the shield open, the privilege check passed, and the password check passed.

Trusted boot code opens the shield by writing 0 when debugging is allowed on this unit. Any write of 1 closes the shield and latches it shut until the next reset. Failed password attempts are counted. After a fixed number of failures the checker locks out and ignores all further attempts until reset. A resume request ends a debug session. It drops the grant, clears the password pass, and hands back the privilege level that was captured when the session started.

Top module: `dbg_access_gate`

## Requirements
- R1: After a synchronous reset, the shield output is 1 (closed) and the shield is unlatched. Debug mode, password pass, lockout and grant are 0, and the effective privilege is user (2'b00).
- R2: A shield write of 0 opens the shield on the next cycle only while the shield is unlatched. A write of 1 closes it and latches it, and later writes of 0 have no effect until reset.
- R3: While the shield is 1, a debug request never sets debug mode and the grant stays 0. Closing the shield during a session drops the grant at once and clears debug mode on the following cycle.
- R4: With the shield open, a request sets debug mode on the next cycle only if the sampled privilege is machine (2'b11) with the machine break-enable set, or user (2'b00) with the user break-enable set. Supervisor (2'b01) and 2'b10 are always refused.
- R5: The grant is 1 exactly when debug mode, the password pass and an open shield all hold. While the grant is 1 the effective privilege is machine (2'b11); otherwise it is the held privilege.
- R6: A password attempt compares all PWD_W bits in one cycle. A match sets the pass output on the next cycle, and a mismatch clears it.
- R7: Each mismatching attempt adds one to a failure count that saturates at MAX_FAIL. At MAX_FAIL the lockout output is 1, and attempts are then ignored: pass stays 0 even for the correct password.
- R8: A request that passes the privilege check while the password pass is 0 sets debug mode but never raises the grant or the effective privilege.
- R9: A resume request in debug mode clears debug mode and the pass on the next cycle. For that cycle the effective privilege is the level sampled in the request cycle, even if the core privilege changed during the session.
- R10: A debug request made while already in debug mode is ignored and does not re-capture the privilege.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shield_wr | input | 1 | Shield write strobe |
| shield_val | input | 1 | Shield value to write (1 = closed) |
| core_priv | input | 2 | Current core privilege (00 user, 01 supervisor, 11 machine) |
| brk_en_m | input | 1 | Machine-level break enable |
| brk_en_u | input | 1 | User-level break enable |
| dbg_req | input | 1 | Debug-entry request |
| resume_req | input | 1 | Leave debug mode |
| pwd_valid | input | 1 | Password attempt strobe |
| pwd_data | input | PWD_W | Password attempt value |
| shield_o | output | 1 | Shield state (1 = debugger disabled) |
| dbg_mode_o | output | 1 | Registered debug-mode flag |
| pwd_ok_o | output | 1 | Password pass |
| lockout_o | output | 1 | Password attempts locked out |
| dbg_grant_o | output | 1 | Debug access granted |
| priv_eff_o | output | 2 | Effective privilege |

## Verification
The bench goes after the case where the privilege check passes and the password check fails. A gate that ORs the two checks would raise the grant and show machine privilege there. It reopens the shield after a write of 1; a missing latch would let the port open again. It closes the shield in the middle of a session and compares the grant in that same cycle. It changes the core privilege during a session, then resumes. A design that tracked the live privilege instead of the captured one would show the wrong level in the cycle after exit. It drives the correct password after lockout, where a checker that kept comparing would raise the pass again.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_U = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/dbg_shield_ctrl.sv
module dbg_shield_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_val,
  output logic shield_o
);
  logic shield_q;
  logic latched_q;

  // closed and unlatched from reset; a close latches until reset
  always_ff @(posedge clk) begin
    if (rst) begin
      shield_q  <= 1'b1;
      latched_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_val) begin
        shield_q  <= 1'b1;
        latched_q <= 1'b1;
      end else if (!latched_q) begin
        shield_q  <= 1'b0;
      end
    end
  end

  assign shield_o = shield_q;

  AST_SHIELD_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> shield_q); // R1
  AST_SHIELD_STICKY: assert property (@(posedge clk) disable iff (rst)
    latched_q |=> shield_q); // R2
endmodule

// File: rtl/dbg_pwd_check.sv
module dbg_pwd_check #(
  parameter int PWD_W = 32,
  parameter logic [PWD_W-1:0] SECRET = '0,
  parameter int MAX_FAIL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             try_valid,
  input  logic [PWD_W-1:0] try_data,
  input  logic             clear,
  output logic             pass_o,
  output logic             lockout_o
);
  localparam int CNT_W = $clog2(MAX_FAIL + 1);
  localparam logic [CNT_W-1:0] FAIL_MAX = CNT_W'(MAX_FAIL);

  logic             pass_q;
  logic [CNT_W-1:0] fail_q;
  logic             locked;
  logic             match;
  logic             attempt;

  assign locked  = (fail_q == FAIL_MAX);
  assign match   = (try_data == SECRET);
  assign attempt = try_valid && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= 1'b0;
      fail_q <= '0;
    end else begin
      if (clear)        pass_q <= 1'b0;
      else if (attempt) pass_q <= match;
      if (attempt && !match && !locked) fail_q <= fail_q + 1'b1;
    end
  end

  assign pass_o    = pass_q;
  assign lockout_o = locked;

  AST_PASS_FROM_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_q) |-> $past(try_valid && try_data == SECRET)); // R6
  AST_LOCK_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    locked |-> !pass_q); // R7
  AST_FAIL_SAT: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R7
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shield,
  input  logic              req,
  input  logic              resume,
  input  logic [PRIV_W-1:0] core_priv,
  input  logic              brk_m,
  input  logic              brk_u,
  output logic              mode_o,
  output logic              exit_o,
  output logic [PRIV_W-1:0] priv_hold_o
);
  logic              mode_q, mode_d;
  logic [PRIV_W-1:0] priv_q;
  logic              priv_ok;

  always_comb begin
    case (core_priv)
      PRIV_M:  priv_ok = brk_m;
      PRIV_U:  priv_ok = brk_u;
      default: priv_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (shield)      mode_d = 1'b0;
    else if (mode_q) mode_d = !resume;
    else             mode_d = req && priv_ok;
  end

  assign exit_o = mode_q && (resume || shield);

  // privilege tracks the core outside debug and is frozen inside it
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      priv_q <= PRIV_U;
    end else begin
      mode_q <= mode_d;
      if (!mode_q) priv_q <= core_priv;
    end
  end

  assign mode_o      = mode_q;
  assign priv_hold_o = priv_q;

  AST_ENTRY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q) |-> $past(req && !shield)); // R4
  AST_SHIELD_ENDS_MODE: assert property (@(posedge clk) disable iff (rst)
    shield |=> !mode_q); // R3
  AST_RESUME_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode_q && resume) |=> !mode_q); // R9
  AST_PRIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode_q && $past(mode_q)) |-> $stable(priv_q)); // R10
endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
  import dbg_gate_pkg::*;
#(
  parameter int PWD_W = 32,
  parameter logic [PWD_W-1:0] SECRET = 32'hC0DE_5EC7,
  parameter int MAX_FAIL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shield_wr,
  input  logic             shield_val,
  input  logic [1:0]       core_priv,
  input  logic             brk_en_m,
  input  logic             brk_en_u,
  input  logic             dbg_req,
  input  logic             resume_req,
  input  logic             pwd_valid,
  input  logic [PWD_W-1:0] pwd_data,
  output logic             shield_o,
  output logic             dbg_mode_o,
  output logic             pwd_ok_o,
  output logic             lockout_o,
  output logic             dbg_grant_o,
  output logic [1:0]       priv_eff_o
);
  logic              shield;
  logic              mode;
  logic              exit_s;
  logic              pass;
  logic              lockout;
  logic [PRIV_W-1:0] priv_hold;

  dbg_shield_ctrl u_shield (
    .clk(clk), .rst(rst), .wr_en(shield_wr), .wr_val(shield_val),
    .shield_o(shield)
  );

  dbg_pwd_check #(.PWD_W(PWD_W), .SECRET(SECRET), .MAX_FAIL(MAX_FAIL)) u_pwd (
    .clk(clk), .rst(rst), .try_valid(pwd_valid), .try_data(pwd_data),
    .clear(exit_s), .pass_o(pass), .lockout_o(lockout)
  );

  dbg_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .shield(shield), .req(dbg_req), .resume(resume_req),
    .core_priv(core_priv), .brk_m(brk_en_m), .brk_u(brk_en_u),
    .mode_o(mode), .exit_o(exit_s), .priv_hold_o(priv_hold)
  );

  // both checks and an open shield; driven from flops only
  logic grant;
  assign grant = mode && pass && !shield;

  assign shield_o    = shield;
  assign dbg_mode_o  = mode;
  assign pwd_ok_o    = pass;
  assign lockout_o   = lockout;
  assign dbg_grant_o = grant;
  assign priv_eff_o  = grant ? PRIV_M : priv_hold;

  AST_NO_GRANT_SHIELDED: assert property (@(posedge clk) disable iff (rst)
    shield_o |-> !dbg_grant_o); // R3
  AST_PRIV_RAISE_NEEDS_PWD: assert property (@(posedge clk) disable iff (rst)
    (priv_eff_o == PRIV_M && priv_hold != PRIV_M) |-> pwd_ok_o); // R8
endmodule

// File: tb/sim_dbg_access_gate.sv
`timescale 1ns/1ps
module sim_dbg_access_gate;
  localparam int W = 32;
  localparam logic [W-1:0] KEY = 32'hC0DE_5EC7;
  localparam int MAXF = 3;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst = 1, shield_wr = 0, shield_val = 0, brk_en_m = 0, brk_en_u = 0;
  logic dbg_req = 0, resume_req = 0, pwd_valid = 0;
  logic [1:0] core_priv = 2'b00;
  logic [W-1:0] pwd_data = '0;
  logic shield_o, dbg_mode_o, pwd_ok_o, lockout_o, dbg_grant_o;
  logic [1:0] priv_eff_o;

  dbg_access_gate #(.PWD_W(W), .SECRET(KEY), .MAX_FAIL(MAXF)) u0 (
    .clk(clk), .rst(rst), .shield_wr(shield_wr), .shield_val(shield_val),
    .core_priv(core_priv), .brk_en_m(brk_en_m), .brk_en_u(brk_en_u),
    .dbg_req(dbg_req), .resume_req(resume_req), .pwd_valid(pwd_valid),
    .pwd_data(pwd_data), .shield_o(shield_o), .dbg_mode_o(dbg_mode_o),
    .pwd_ok_o(pwd_ok_o), .lockout_o(lockout_o), .dbg_grant_o(dbg_grant_o),
    .priv_eff_o(priv_eff_o)
  );

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1";

  // behavioural reference model
  bit m_shield = 1, m_latch = 0, m_pass = 0, m_mode = 0;
  int m_fail = 0;
  int m_priv = 0;

  always @(posedge clk) begin
    bit ok_priv, n_shield, n_latch, n_pass, n_mode, leaving;
    int n_fail, n_priv;
    cycles++;
    if (rst) begin
      m_shield = 1; m_latch = 0; m_pass = 0; m_mode = 0; m_fail = 0; m_priv = 0;
    end else begin
      n_shield = m_shield; n_latch = m_latch;
      if (shield_wr && shield_val) begin n_shield = 1; n_latch = 1; end
      else if (shield_wr && !m_latch) n_shield = 0;
      ok_priv = (core_priv == 2'b11) ? brk_en_m : (core_priv == 2'b00) ? brk_en_u : 0;
      leaving = m_mode && (resume_req || m_shield);
      if (m_shield) n_mode = 0;
      else if (m_mode) n_mode = !resume_req;
      else n_mode = dbg_req && ok_priv;
      n_pass = m_pass; n_fail = m_fail;
      if (pwd_valid && m_fail < MAXF) begin
        if (pwd_data == KEY) n_pass = 1;
        else begin n_pass = 0; n_fail = m_fail + 1; end
      end
      if (leaving) n_pass = 0;
      n_priv = m_mode ? m_priv : int'(core_priv);
      m_shield = n_shield; m_latch = n_latch; m_pass = n_pass;
      m_mode = n_mode; m_fail = n_fail; m_priv = n_priv;
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  task automatic tick();
    bit g;
    @(posedge clk); #2;
    g = m_mode && m_pass && !m_shield;
    chk("shield", shield_o, m_shield);
    chk("mode", dbg_mode_o, m_mode);
    chk("pass", pwd_ok_o, m_pass);
    chk("lockout", lockout_o, (m_fail >= MAXF));
    chk("grant", dbg_grant_o, g);
    chk("priv_eff", priv_eff_o, g ? 3 : m_priv);
    shield_wr = 0; dbg_req = 0; resume_req = 0; pwd_valid = 0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    rst = 1; wait_n(2); rst = 0; wait_n(1);
  endtask

  task automatic wr_shield(bit v); shield_wr = 1; shield_val = v; tick(); endtask
  task automatic try_pwd(logic [W-1:0] d); pwd_valid = 1; pwd_data = d; tick(); endtask
  task automatic request(logic [1:0] p); core_priv = p; dbg_req = 1; tick(); endtask
  task automatic resume(); resume_req = 1; tick(); endtask

  initial begin
    #1;
    phase = "R1"; do_reset();
    // direct spot checks of the reset values
    chk("R1 shield reset", shield_o, 1);
    chk("R1 grant reset", dbg_grant_o, 0);

    phase = "R3"; brk_en_m = 1; brk_en_u = 1;
    try_pwd(KEY); request(2'b11); wait_n(2);
    chk("R3 closed no grant", dbg_grant_o, 0);

    phase = "R2"; wr_shield(0); wait_n(1);
    chk("R2 opened", shield_o, 0);

    phase = "R5"; request(2'b11); wait_n(1);
    chk("R5 grant", dbg_grant_o, 1);
    chk("R5 priv M", priv_eff_o, 3);
    phase = "R9"; resume(); wait_n(1);

    phase = "R9"; try_pwd(KEY); request(2'b00);
    core_priv = 2'b01; wait_n(2);
    phase = "R10"; request(2'b11); core_priv = 2'b01; wait_n(1);
    phase = "R9"; resume_req = 1; tick();
    chk("R9 restored user", priv_eff_o, 0);
    wait_n(1);
    chk("R9 tracks live", priv_eff_o, 1);

    phase = "R4"; try_pwd(KEY);
    request(2'b01); wait_n(1); request(2'b10); wait_n(1);
    brk_en_m = 0; request(2'b11); wait_n(1);
    brk_en_u = 0; request(2'b00); wait_n(1);
    chk("R4 refused", dbg_mode_o, 0);
    brk_en_m = 1; brk_en_u = 1;

    phase = "R8"; try_pwd(KEY ^ 32'h1); request(2'b00); wait_n(2);
    chk("R8 mode set", dbg_mode_o, 1);
    chk("R8 no grant", dbg_grant_o, 0);
    chk("R8 no raise", priv_eff_o, 0);
    resume(); wait_n(1);

    phase = "R3"; do_reset(); wr_shield(0); try_pwd(KEY); request(2'b11); wait_n(1);
    wr_shield(1);
    chk("R3 grant drops", dbg_grant_o, 0);
    wait_n(1);
    phase = "R2"; wr_shield(0); wait_n(1);
    chk("R2 sticky", shield_o, 1);

    phase = "R1"; do_reset();
    phase = "R6"; wr_shield(0); try_pwd(KEY); try_pwd(KEY ^ 32'h8000_0000);
    chk("R6 mismatch clears", pwd_ok_o, 0);
    phase = "R7"; try_pwd(32'h0); try_pwd(32'hFFFF_FFFF); wait_n(1);
    chk("R7 locked", lockout_o, 1);
    try_pwd(KEY); wait_n(1);
    chk("R7 ignored", pwd_ok_o, 0);
    request(2'b11); wait_n(2);
    chk("R7 no grant", dbg_grant_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule